// File: doc/BRIEF.md
# Memory-Mapped Arithmetic and Branch-Condition Unit

This block sits on the data bus of a small processor that has only a move instruction. It claims the eight highest addresses of the address space. Inside that window it keeps two operand registers. The processor reads results back from the same addresses: the sum of the operands from one slot and their bitwise NAND from the next. The operand registers cannot be read back directly.

An unsigned comparator and the adder's carry-out give three condition flags. The block decodes writes to the four branch slots and combines each one with its flag. The result is a single load request that tells the processor's program counter to take the written value. Two more slots connect a front-panel row of lamps and a row of push-buttons. A write sets the lamps. A read returns the buttons, which are wired active-low, so their level is inverted before it reaches the bus.

Writes are sampled on the rising clock edge while the write strobe is low. Reads and the branch request are combinational from the address and the strobes.

Top module: `mmio_alu_unit`

## Requirements
- R1: After reset both operand registers and both lamp rows are zero, so a read of the sum slot (offset 0, address 0xF8) returns 0x00.
- R2: A clocked write with the write strobe low stores write data into operand A at offset 0 (0xF8) or operand B at offset 1 (0xF9).
- R3: While the read strobe is low, a read of offset 0 (0xF8) returns (A + B) modulo 2^DATA_W.
- R4: While the read strobe is low, a read of offset 1 (0xF9) returns the bitwise NAND of A and B.
- R5: carry_flag is the carry-out of A + B. equal_flag is A == B. greater_flag is A > B, with both operands taken as unsigned. equal_flag and greater_flag are never high together.
- R6: pc_load is high only while the write strobe is low. With the strobe low it is high for offset 7 (0xFF) unconditionally, for offset 6 (0xFE) when carry_flag is set, for offset 5 (0xFD) when equal_flag is set, and for offset 4 (0xFC) when greater_flag is set. Every other address gives 0.
- R7: A write to offset 2 (0xFA) sets addr_led and a write to offset 3 (0xFB) sets data_led. A read of those offsets returns the bitwise inverse of addr_sw_n and data_sw_n respectively.
- R8: rd_data is 0x00 whenever the read strobe is high, the address is outside the window, or the address is one of the branch slots 0xFC to 0xFF.
- R9: A write outside the window, or to a branch slot, leaves A, B and both lamp rows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| rd_data | output | DATA_W | Read data, zero when not selected |
| carry_flag | output | 1 | Carry-out of A + B |
| equal_flag | output | 1 | A equals B |
| greater_flag | output | 1 | A greater than B, unsigned |
| pc_load | output | 1 | Branch request to the program counter |
| addr_sw_n | input | DATA_W | Address-row buttons, active low |
| data_sw_n | input | DATA_W | Data-row buttons, active low |
| addr_led | output | DATA_W | Address-row lamps |
| data_led | output | DATA_W | Data-row lamps |

## Verification
The bench builds the block with the default ADDR_W = 8 and DATA_W = 8. With these values the window is 0xF8 to 0xFF. Addresses just below it, such as 0xF7, test the edge of the decoder. The 8-bit width lets operand pairs reach the carry wrap (0xFF + 0x01), equality, and both orders of the unsigned comparison, including values that would compare the other way if they were read as signed.

// File: rtl/mmio_alu_pkg.sv
package mmio_alu_pkg;
    localparam int SLOT_W   = 3;
    localparam int SLOT_CNT = 1 << SLOT_W;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_SUM   = 3'd0,
        SLOT_NAND  = 3'd1,
        SLOT_AIO   = 3'd2,
        SLOT_DIO   = 3'd3,
        SLOT_BR_GT = 3'd4,
        SLOT_BR_EQ = 3'd5,
        SLOT_BR_CY = 3'd6,
        SLOT_BR_AL = 3'd7
    } slot_e;
endpackage

// File: rtl/mmio_win_decode.sv
module mmio_win_decode
    import mmio_alu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output slot_e               slot,
    output logic [SLOT_CNT-1:0] slot_oh
);
    // The window is the top SLOT_CNT addresses: all upper bits set.
    assign hit  = &addr[ADDR_W-1:SLOT_W];
    assign slot = slot_e'(addr[SLOT_W-1:0]);

    for (genvar i = 0; i < SLOT_CNT; i++) begin : g_sel
        assign slot_oh[i] = hit && (addr[SLOT_W-1:0] == SLOT_W'(i));
    end
endmodule

// File: rtl/mmio_reg_bank.sv
module mmio_reg_bank
    import mmio_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_n,
    input  logic [SLOT_CNT-1:0] slot_oh,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   opa,
    output logic [DATA_W-1:0]   opb,
    output logic [DATA_W-1:0]   led_a,
    output logic [DATA_W-1:0]   led_d
);
    typedef struct packed {
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [DATA_W-1:0] led_a;
        logic [DATA_W-1:0] led_d;
    } bank_t;

    bank_t st_d, st_q;
    logic  wr_en;

    assign wr_en = !wr_n;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (slot_oh[SLOT_SUM])  st_d.opa   = wdata;
            if (slot_oh[SLOT_NAND]) st_d.opb   = wdata;
            if (slot_oh[SLOT_AIO])  st_d.led_a = wdata;
            if (slot_oh[SLOT_DIO])  st_d.led_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opa   = st_q.opa;
    assign opb   = st_q.opb;
    assign led_a = st_q.led_a;
    assign led_d = st_q.led_d;

    AST_OPA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot_oh[SLOT_SUM]) |=> (opa == $past(wdata))); // R2
    AST_OPB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot_oh[SLOT_NAND]) |=> (opb == $past(wdata))); // R2
    AST_OPA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && slot_oh[SLOT_SUM]) |=> $stable(opa)); // R9
    AST_LEDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && slot_oh[SLOT_AIO]) |=> $stable(led_a)); // R9
endmodule

// File: rtl/mmio_arith.sv
module mmio_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] nand_out,
    output logic              carry,
    output logic              equal,
    output logic              greater
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, opa} + {1'b0, opb};
        sum      = wide_sum[DATA_W-1:0];
        carry    = wide_sum[DATA_W];
        nand_out = ~(opa & opb);
        equal    = (opa == opb);
        greater  = (opa > opb);
    end
endmodule

// File: rtl/mmio_alu_unit.sv
module mmio_alu_unit
    import mmio_alu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              carry_flag,
    output logic              equal_flag,
    output logic              greater_flag,
    output logic              pc_load,
    input  logic [DATA_W-1:0] addr_sw_n,
    input  logic [DATA_W-1:0] data_sw_n,
    output logic [DATA_W-1:0] addr_led,
    output logic [DATA_W-1:0] data_led
);
    logic                hit;
    slot_e               slot;
    logic [SLOT_CNT-1:0] slot_oh;
    logic [DATA_W-1:0]   opa, opb, sum, nand_out;

    mmio_win_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr    (bus_addr),
        .hit     (hit),
        .slot    (slot),
        .slot_oh (slot_oh)
    );

    mmio_reg_bank #(.DATA_W(DATA_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_n    (bus_wr_n),
        .slot_oh (slot_oh),
        .wdata   (bus_wdata),
        .opa     (opa),
        .opb     (opb),
        .led_a   (addr_led),
        .led_d   (data_led)
    );

    mmio_arith #(.DATA_W(DATA_W)) alu_i (
        .opa      (opa),
        .opb      (opb),
        .sum      (sum),
        .nand_out (nand_out),
        .carry    (carry_flag),
        .equal    (equal_flag),
        .greater  (greater_flag)
    );

    // Read mux: only driven while strobed and inside the window.
    always_comb begin
        rd_data = '0;
        if (!bus_rd_n && hit) begin
            case (slot)
                SLOT_SUM:  rd_data = sum;
                SLOT_NAND: rd_data = nand_out;
                SLOT_AIO:  rd_data = ~addr_sw_n;
                SLOT_DIO:  rd_data = ~data_sw_n;
                default:   rd_data = '0;
            endcase
        end
    end

    // Branch request: each branch slot is qualified by its condition.
    always_comb begin
        pc_load = 1'b0;
        if (!bus_wr_n) begin
            pc_load = slot_oh[SLOT_BR_AL]
                   || (slot_oh[SLOT_BR_CY] && carry_flag)
                   || (slot_oh[SLOT_BR_EQ] && equal_flag)
                   || (slot_oh[SLOT_BR_GT] && greater_flag);
        end
    end

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n |-> (rd_data == '0)); // R8
    AST_JUMP_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !bus_wr_n); // R6
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(equal_flag && greater_flag)); // R5
endmodule

// File: tb/mmio_alu_unit_tb.sv
module mmio_alu_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic [7:0] rd_data;
    logic       carry_flag, equal_flag, greater_flag, pc_load;
    logic [7:0] addr_sw_n = 8'hFF;
    logic [7:0] data_sw_n = 8'hFF;
    logic [7:0] addr_led, data_led;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk; // 250 MHz

    mmio_alu_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .rd_data      (rd_data),
        .carry_flag   (carry_flag),
        .equal_flag   (equal_flag),
        .greater_flag (greater_flag),
        .pc_load      (pc_load),
        .addr_sw_n    (addr_sw_n),
        .data_sw_n    (data_sw_n),
        .addr_led     (addr_led),
        .data_led     (data_led)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_n = 1'b0;
        @(negedge clk);
        bus_wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd_n = 1'b0;
        #0.5;
        d = rd_data;
        bus_rd_n = 1'b1;
        #0.1;
    endtask

    // Strobe a write without a clock edge and sample the branch request.
    task automatic probe_jump(input logic [7:0] a, output logic pl);
        @(negedge clk);
        bus_addr = a; bus_wr_n = 1'b0;
        #0.5;
        pl = pc_load;
        bus_wr_n = 1'b1;
        #0.1;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        bus_read(8'hF8, r);
        check("R1 sum after reset", r, 8'h00);
        check("R1 addr_led after reset", addr_led, 8'h00);
        check("R1 data_led after reset", data_led, 8'h00);
    endtask

    task automatic t_operands(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        logic [8:0] full;
        logic       pl;
        full = {1'b0, a} + {1'b0, b};
        bus_write(8'hF8, a);
        bus_write(8'hF9, b);
        bus_read(8'hF8, r);
        check("R2 R3 sum read", r, full[7:0]);
        bus_read(8'hF9, r);
        check("R2 R4 nand read", r, ~(a & b));
        check("R5 carry_flag", {7'd0, carry_flag}, {7'd0, full[8]});
        check("R5 equal_flag", {7'd0, equal_flag}, {7'd0, a == b});
        check("R5 greater_flag", {7'd0, greater_flag}, {7'd0, a > b});
        probe_jump(8'hFF, pl);
        check("R6 jump always", {7'd0, pl}, 8'd1);
        probe_jump(8'hFE, pl);
        check("R6 jump on carry", {7'd0, pl}, {7'd0, full[8]});
        probe_jump(8'hFD, pl);
        check("R6 jump on equal", {7'd0, pl}, {7'd0, a == b});
        probe_jump(8'hFC, pl);
        check("R6 jump on greater", {7'd0, pl}, {7'd0, a > b});
        probe_jump(8'hF9, pl);
        check("R6 no jump for operand slot", {7'd0, pl}, 8'd0);
        check("R6 no request with strobe high", {7'd0, pc_load}, 8'd0);
    endtask

    task automatic t_panel();
        logic [7:0] r;
        bus_write(8'hFA, 8'h5C);
        bus_write(8'hFB, 8'hA3);
        check("R7 addr_led", addr_led, 8'h5C);
        check("R7 data_led", data_led, 8'hA3);
        addr_sw_n = 8'hF0; data_sw_n = 8'h7E;
        #0.1;
        bus_read(8'hFA, r);
        check("R7 addr switch read", r, 8'h0F);
        bus_read(8'hFB, r);
        check("R7 data switch read", r, 8'h81);
        addr_sw_n = 8'hFF; data_sw_n = 8'hFF;
    endtask

    task automatic t_reserved();
        logic [7:0] r;
        bus_write(8'hF8, 8'h11);
        bus_write(8'hF9, 8'h22);
        for (int a = 8'hFC; a <= 8'hFF; a++) begin
            bus_read(8'(a), r);
            check("R8 branch slot read", r, 8'h00);
        end
        bus_read(8'hF7, r);
        check("R8 read below window", r, 8'h00);
        bus_addr = 8'hF8;
        #0.5;
        check("R8 read strobe high", rd_data, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] r;
        bus_write(8'hF8, 8'h30);
        bus_write(8'hF9, 8'h05);
        bus_write(8'hFA, 8'h66);
        bus_write(8'hF7, 8'hEE);
        bus_write(8'h38, 8'hEE);
        bus_write(8'h78, 8'hEE);
        bus_write(8'hFF, 8'hEE);
        bus_write(8'hFC, 8'hEE);
        bus_read(8'hF8, r);
        check("R9 operands kept (sum)", r, 8'h35);
        bus_read(8'hF9, r);
        check("R9 operands kept (nand)", r, 8'hFF);
        check("R9 addr_led kept", addr_led, 8'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_operands(8'h12, 8'h34);
        t_operands(8'hC8, 8'h64);
        t_operands(8'hFF, 8'h01);
        t_operands(8'h7F, 8'h7F);
        t_operands(8'h80, 8'h7F);
        t_operands(8'h01, 8'hFE);
        t_operands(8'h00, 8'h00);
        t_panel();
        t_reserved();
        t_ignored();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule